// File: doc/BRIEF.md
# Set-associative translation lookaside buffer

This block keeps recently used page-table and page-directory entries so a 32-bit virtual address can be turned into a physical address without walking the tables in memory. Each lookup presents a 20-bit virtual page number and a 12-bit page offset. The buffer probes two sets in the same cycle. One holds table entries, indexed by the low bits of the page number. The other holds directory entries, indexed by the low bits of the 10-bit directory index. One cycle later it reports a registered hit, a physical address and the cached entry word.

When the table entry is missing but the directory entry is cached, the response carries that directory entry. The walker can then skip the first level of its walk. After a walk, the walker writes the result back through a fill strobe. The block places it in the matching way if one exists, otherwise in the lowest free way, otherwise in the way a tree pseudo-LRU picks. A task-switch flush drops every entry not marked global. A full invalidate drops everything.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is held and in any cycle with no lookup in the cycle before, `rsp_valid`, `rsp_hit` and `rsp_dir_hit` are 0. After reset every lookup misses.
- R2: A table-entry fill (`fill_dir`=0) uses set `vpn[3:0]` and tag `vpn[19:4]`. A later lookup of the same page number hits with `rsp_valid`=1 one cycle after `lk_valid`. A page number in another set, or with another tag in the same set, misses.
- R3: On a table hit, `rsp_paddr` is entry bits [31:12] followed by `lk_off` unchanged, and `rsp_entry` is the full 32-bit cached entry.
- R4: A directory fill (`fill_dir`=1) uses set `vpn[13:10]` and key `vpn[19:10]`. A lookup whose `vpn[19:10]` matches, with no table hit, gives `rsp_hit`=0, `rsp_dir_hit`=1 and `rsp_entry` set to the directory entry. A directory entry never gives a table hit, even when its stored key equals a table tag in the same set.
- R5: When both a table entry and a directory entry match, the table hit wins: `rsp_hit`=1 and `rsp_dir_hit`=0.
- R6: On a miss, `rsp_paddr` is 0. `rsp_entry` is 0 unless R4 applies.
- R7: A fill of a new key takes the lowest-numbered invalid way of its set. In a full set it replaces the way chosen by a 3-bit tree pseudo-LRU that both table hits and fills update.
- R8: A fill whose key already sits in the set overwrites that way. No key is ever held twice, and the other ways are kept.
- R9: `flush_task` invalidates every entry whose bit 8 (global) is 0 and keeps every entry whose bit 8 is 1.
- R10: `flush_all` invalidates every entry, global ones included.
- R11: A fill presented in the same cycle as either flush is dropped.
- R12: A lookup in the same cycle as a fill sees the contents from before the fill. The filled entry is visible to a lookup in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed through to the physical address |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_dir | input | 1 | 1: fill is a directory entry, 0: table entry |
| fill_vpn | input | 20 | Page number the fill belongs to |
| fill_entry | input | 32 | Entry word to install |
| flush_task | input | 1 | Task-switch flush that spares global entries |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Table entry hit |
| rsp_dir_hit | output | 1 | Only the directory entry hit |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_entry | output | 32 | Cached entry word that produced the response |

## Verification
The embedded properties check on every cycle that no key is ever cached twice and that a fill of a new key lands in a free way while one exists. They also check that misses carry a zero address, that a hit keeps the offset, that table and directory hits exclude each other, and what the stored contents look like right after each flush. Only the bench scenarios can show the things that depend on history. These are the exact pseudo-LRU victim after a hit reorders a full set, a refill overwriting data in place, fills dropped under a flush, and the same-cycle ordering between a fill and a lookup.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, entry type and index/replacement helpers for the
// translation buffer. Assumes WAYS is a power of two of at least 2.
package tlb_pkg;
    parameter int VPN_W      = 20;
    parameter int OFF_W      = 12;
    parameter int SET_W      = 4;
    parameter int WAYS       = 4;
    parameter int DIR_W      = 10;
    parameter int PTE_W      = 32;
    parameter int GLOBAL_POS = 8;

    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int PA_W  = PTE_W;

    typedef logic [SET_W-1:0] set_idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAYS-2:0]  tree_t;

    typedef struct packed {
        logic             valid;
        logic             dir;
        tag_t             tag;
        logic [PTE_W-1:0] data;
    } tlb_entry_t;

    // Set used by a table entry: low page-number bits.
    function automatic set_idx_t tbl_set(input logic [VPN_W-1:0] vpn);
        return vpn[SET_W-1:0];
    endfunction

    // Tag of a table entry: remaining high page-number bits.
    function automatic tag_t tbl_tag(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:SET_W];
    endfunction

    // Set used by a directory entry: low bits of the directory index.
    function automatic set_idx_t dir_set(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-DIR_W +: SET_W];
    endfunction

    // Key of a directory entry: the whole directory index, zero-extended.
    function automatic tag_t dir_key(input logic [VPN_W-1:0] vpn);
        return tag_t'(vpn[VPN_W-1 -: DIR_W]);
    endfunction

    // Tree update: make every node on the path point away from way w.
    function automatic tree_t plru_touch(input tree_t t, input way_t w);
        tree_t n;
        int    node;
        logic  d;
        n    = t;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            d       = w[WAY_W-1-l];
            n[node] = ~d;
            node    = 2 * node + 1 + int'(d);
        end
        return n;
    endfunction

    // Tree walk: follow the node bits down to the victim leaf.
    function automatic way_t plru_victim(input tree_t t);
        int node;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            node = 2 * node + 1 + int'(t[node]);
        end
        return way_t'(node - (WAYS - 1));
    endfunction
endpackage

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
// Module: entry storage for all sets and ways. Provides three combinational
// set read ports (table probe, directory probe, fill target). Flushes beat
// writes. Assumes the caller gates writes during flushes.
module tlb_store
    import tlb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_all,
    input  logic                   flush_task,
    input  logic                   wr_en,
    input  set_idx_t               wr_set,
    input  way_t                   wr_way,
    input  tlb_entry_t             wr_entry,
    input  set_idx_t               rd_a_set,
    input  set_idx_t               rd_b_set,
    input  set_idx_t               rd_c_set,
    output tlb_entry_t [WAYS-1:0]  rd_a,
    output tlb_entry_t [WAYS-1:0]  rd_b,
    output tlb_entry_t [WAYS-1:0]  rd_c
);
    tlb_entry_t [WAYS-1:0] mem [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            tlb_entry_t ent;
            // Per-entry register: reset, flush, or targeted write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent <= '0;
                end else if (flush_all) begin
                    ent.valid <= 1'b0;
                end else if (flush_task) begin
                    if (!ent.data[GLOBAL_POS]) ent.valid <= 1'b0;
                end else if (wr_en && wr_set == set_idx_t'(s) && wr_way == way_t'(w)) begin
                    ent <= wr_entry;
                end
            end
            assign mem[s][w] = ent;
        end
    end

    assign rd_a = mem[rd_a_set];
    assign rd_b = mem[rd_b_set];
    assign rd_c = mem[rd_c_set];

    // Summary vectors used only by the flush properties below.
    logic [SETS*WAYS-1:0] valid_vec, keep_vec;
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                valid_vec[s*WAYS+w] = mem[s][w].valid;
                keep_vec[s*WAYS+w]  = mem[s][w].valid && mem[s][w].data[GLOBAL_POS];
            end
        end
    end

    p_flush_all_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));
    p_flush_task_drops_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_task && !flush_all) |=> (valid_vec == keep_vec));
    p_flush_task_keeps_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_task && !flush_all) |=> (keep_vec == $past(keep_vec)));
endmodule

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
// Module: compares one set's ways against a key of a given kind (table or
// directory). Pure combinational; reports the hit vector and encoded way.
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] ways,
    input  logic                  want_dir,
    input  tag_t                  key,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output way_t                  hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = ways[w].valid && (ways[w].dir == want_dir) && (ways[w].tag == key);
    end

    assign hit = |hit_vec;

    // Encode the matching way (at most one is set by construction of fills).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end
endmodule

// File: rtl/tlb_plru.sv
`timescale 1ns/1ps
// Module: per-set tree pseudo-LRU state. Two touch ports (lookup hit and
// fill); when both touch the same set in one cycle the fill is applied last.
module tlb_plru
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit_touch,
    input  set_idx_t hit_set,
    input  way_t     hit_way,
    input  logic     fill_touch,
    input  set_idx_t fill_set,
    input  way_t     fill_way,
    input  set_idx_t query_set,
    output way_t     victim
);
    tree_t trees [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_tree
        tree_t t;
        tree_t nxt;
        // Next state: apply hit touch, then fill touch on top of it.
        always_comb begin
            nxt = t;
            if (hit_touch && hit_set == set_idx_t'(s))   nxt = plru_touch(nxt, hit_way);
            if (fill_touch && fill_set == set_idx_t'(s)) nxt = plru_touch(nxt, fill_way);
        end
        // Tree register for this set.
        always_ff @(posedge clk) begin
            if (!rst_n) t <= '0;
            else        t <= nxt;
        end
        assign trees[s] = t;
    end

    assign victim = plru_victim(trees[query_set]);
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
// Module: top of the translation buffer. Probes the table set and the
// directory set of each lookup in parallel, registers the response, and
// installs walker fills (matching way, else first free, else pseudo-LRU).
// Assumes at most one fill per cycle and that flushes outrank fills.
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [OFF_W-1:0]  lk_off,
    input  logic              fill_valid,
    input  logic              fill_dir,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PTE_W-1:0]  fill_entry,
    input  logic              flush_task,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dir_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PTE_W-1:0]  rsp_entry
);
    // Lookup indices.
    set_idx_t lk_tset, lk_dset, f_set;
    tag_t     lk_ttag, lk_dkey, f_tag;
    assign lk_tset = tbl_set(lk_vpn);
    assign lk_ttag = tbl_tag(lk_vpn);
    assign lk_dset = dir_set(lk_vpn);
    assign lk_dkey = dir_key(lk_vpn);
    assign f_set   = fill_dir ? dir_set(fill_vpn) : tbl_set(fill_vpn);
    assign f_tag   = fill_dir ? dir_key(fill_vpn) : tbl_tag(fill_vpn);

    tlb_entry_t [WAYS-1:0] t_ways, d_ways, f_ways;
    logic                  wr_en;
    way_t                  wr_way;
    tlb_entry_t            wr_entry;

    tlb_store u_store (
        .clk(clk), .rst_n(rst_n),
        .flush_all(flush_all), .flush_task(flush_task),
        .wr_en(wr_en), .wr_set(f_set), .wr_way(wr_way), .wr_entry(wr_entry),
        .rd_a_set(lk_tset), .rd_b_set(lk_dset), .rd_c_set(f_set),
        .rd_a(t_ways), .rd_b(d_ways), .rd_c(f_ways)
    );

    logic [WAYS-1:0] t_vec, d_vec, f_vec;
    logic            t_hit, d_hit, f_hit;
    way_t            t_way, d_way, f_way;

    tlb_match u_tmatch (.ways(t_ways), .want_dir(1'b0), .key(lk_ttag),
                        .hit_vec(t_vec), .hit(t_hit), .hit_way(t_way));
    tlb_match u_dmatch (.ways(d_ways), .want_dir(1'b1), .key(lk_dkey),
                        .hit_vec(d_vec), .hit(d_hit), .hit_way(d_way));
    tlb_match u_fmatch (.ways(f_ways), .want_dir(fill_dir), .key(f_tag),
                        .hit_vec(f_vec), .hit(f_hit), .hit_way(f_way));

    logic [PTE_W-1:0] t_data, d_data;
    assign t_data = t_ways[t_way].data;
    assign d_data = d_ways[d_way].data;

    // Free-way search in the fill set: lowest invalid way wins.
    logic [WAYS-1:0] free_vec;
    way_t            free_way;
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            free_vec[w] = !f_ways[w].valid;
            if (!f_ways[w].valid) free_way = way_t'(w);
        end
    end

    way_t plru_way;
    tlb_plru u_plru (
        .clk(clk), .rst_n(rst_n),
        .hit_touch(lk_valid && t_hit), .hit_set(lk_tset), .hit_way(t_way),
        .fill_touch(wr_en), .fill_set(f_set), .fill_way(wr_way),
        .query_set(f_set), .victim(plru_way)
    );

    // Fill placement: refresh in place, else free way, else victim.
    always_comb begin
        wr_en          = fill_valid && !flush_all && !flush_task;
        wr_entry.valid = 1'b1;
        wr_entry.dir   = fill_dir;
        wr_entry.tag   = f_tag;
        wr_entry.data  = fill_entry;
        if (f_hit)          wr_way = f_way;
        else if (|free_vec) wr_way = free_way;
        else                wr_way = plru_way;
    end

    // Registered response to the lookup of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_dir_hit <= 1'b0;
            rsp_paddr   <= '0;
            rsp_entry   <= '0;
        end else begin
            rsp_valid   <= lk_valid;
            rsp_hit     <= lk_valid && t_hit;
            rsp_dir_hit <= lk_valid && !t_hit && d_hit;
            rsp_paddr   <= (lk_valid && t_hit) ? {t_data[PTE_W-1:OFF_W], lk_off} : '0;
            if (!lk_valid)  rsp_entry <= '0;
            else if (t_hit) rsp_entry <= t_data;
            else if (d_hit) rsp_entry <= d_data;
            else            rsp_entry <= '0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_dir_hit));
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_off)));
    p_hits_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !rsp_dir_hit);
    p_miss_zero_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
    p_free_way_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !f_hit && (|free_vec)) |-> !f_ways[wr_way].valid);
    p_table_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(t_vec));
    p_dir_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(d_vec));
    p_fill_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(f_vec));
endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic        fill_valid = 1'b0;
    logic        fill_dir = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [31:0] fill_entry = '0;
    logic        flush_task = 1'b0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_dir_hit;
    logic [31:0] rsp_paddr, rsp_entry;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string       req;
        logic        hit;
        logic        dir;
        logic [31:0] pa;
        logic [31:0] ent;
    } exp_t;
    exp_t sb[$];

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .fill_valid(fill_valid), .fill_dir(fill_dir), .fill_vpn(fill_vpn),
        .fill_entry(fill_entry), .flush_task(flush_task), .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dir_hit(rsp_dir_hit),
        .rsp_paddr(rsp_paddr), .rsp_entry(rsp_entry)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Driver: one lookup, expectation pushed to the scoreboard.
    task automatic lookup(string req, logic [19:0] vpn, logic [11:0] off,
                          logic hit, logic dir, logic [31:0] pa, logic [31:0] ent);
        exp_t e;
        e.req = req; e.hit = hit; e.dir = dir; e.pa = pa; e.ent = ent;
        sb.push_back(e);
        lk_valid = 1'b1; lk_vpn = vpn; lk_off = off;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic fill(logic dir, logic [19:0] vpn, logic [31:0] ent);
        fill_valid = 1'b1; fill_dir = dir; fill_vpn = vpn; fill_entry = ent;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R1", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "hit", {31'd0, rsp_hit}, {31'd0, e.hit});
                check(e.req, "dir_hit", {31'd0, rsp_dir_hit}, {31'd0, e.dir});
                check(e.req, "paddr", rsp_paddr, e.pa);
                check(e.req, "entry", rsp_entry, e.ent);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1", "rsp_hit in reset", {31'd0, rsp_hit}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 / R6: empty buffer misses.
        lookup("R1", 20'h10000, 12'h123, 0, 0, 32'h0, 32'h0);

        // R2 / R3: table fill then hit.
        fill(1'b0, 20'h10000, 32'h0A000001);
        lookup("R3", 20'h10000, 12'h5A5, 1, 0, 32'h0A0005A5, 32'h0A000001);
        lookup("R2", 20'h10001, 12'h000, 0, 0, 32'h0, 32'h0);
        lookup("R6", 20'h90000, 12'h0FF, 0, 0, 32'h0, 32'h0);

        // R12: same-cycle fill and lookup sees old contents.
        fill_valid = 1'b1; fill_dir = 1'b0; fill_vpn = 20'h00007; fill_entry = 32'h0F000001;
        begin
            exp_t e;
            e.req = "R12"; e.hit = 0; e.dir = 0; e.pa = 0; e.ent = 0;
            sb.push_back(e);
        end
        lk_valid = 1'b1; lk_vpn = 20'h00007; lk_off = 12'h010;
        @(posedge clk); #1;
        fill_valid = 1'b0; lk_valid = 1'b0;
        lookup("R12", 20'h00007, 12'h010, 1, 0, 32'h0F000010, 32'h0F000001);

        // R4: directory entry, key 0x321 in set 1; no aliasing into table hits.
        fill(1'b1, 20'hC8400, 32'h77777003);
        lookup("R4", 20'hC87FF, 12'h111, 0, 1, 32'h0, 32'h77777003);
        lookup("R4", 20'h03211, 12'h000, 0, 0, 32'h0, 32'h0);
        // R5: table hit outranks directory hit.
        fill(1'b0, 20'hC8401, 32'h12345001);
        lookup("R5", 20'hC8401, 12'h010, 1, 0, 32'h12345010, 32'h12345001);

        // R7: fill set 0 (A already in way 0), touch A, new fill evicts C.
        fill(1'b0, 20'h20000, 32'h0B000001);
        fill(1'b0, 20'h30000, 32'h0C000001);
        fill(1'b0, 20'h40000, 32'h0D000001);
        lookup("R7", 20'h10000, 12'h000, 1, 0, 32'h0A000000, 32'h0A000001);
        fill(1'b0, 20'h50000, 32'h0E000001);
        lookup("R7", 20'h30000, 12'h000, 0, 0, 32'h0, 32'h0);
        lookup("R7", 20'h50000, 12'h000, 1, 0, 32'h0E000000, 32'h0E000001);
        lookup("R7", 20'h20000, 12'h000, 1, 0, 32'h0B000000, 32'h0B000001);

        // R8: refill an existing key in a full set overwrites in place.
        fill(1'b0, 20'h40000, 32'h0DDDD001);
        lookup("R8", 20'h40000, 12'h004, 1, 0, 32'h0DDDD004, 32'h0DDDD001);
        lookup("R8", 20'h10000, 12'h000, 1, 0, 32'h0A000000, 32'h0A000001);
        lookup("R8", 20'h50000, 12'h000, 1, 0, 32'h0E000000, 32'h0E000001);
        lookup("R8", 20'h20000, 12'h000, 1, 0, 32'h0B000000, 32'h0B000001);

        // R9 / R11: global entry, then task flush with a colliding fill.
        fill(1'b0, 20'h00009, 32'h09999101);
        fill_valid = 1'b1; fill_dir = 1'b0; fill_vpn = 20'h00005; fill_entry = 32'h05555101;
        flush_task = 1'b1;
        @(posedge clk); #1;
        fill_valid = 1'b0; flush_task = 1'b0;
        lookup("R9", 20'h00009, 12'h123, 1, 0, 32'h09999123, 32'h09999101);
        lookup("R9", 20'h10000, 12'h000, 0, 0, 32'h0, 32'h0);
        lookup("R9", 20'hC87FF, 12'h000, 0, 0, 32'h0, 32'h0);
        lookup("R11", 20'h00005, 12'h000, 0, 0, 32'h0, 32'h0);

        // R10: full invalidate drops the global entry too.
        flush_all = 1'b1;
        @(posedge clk); #1;
        flush_all = 1'b0;
        lookup("R10", 20'h00009, 12'h000, 0, 0, 32'h0, 32'h0);

        // R2: buffer still installs after a full invalidate.
        fill(1'b0, 20'h10000, 32'h0A000001);
        lookup("R2", 20'h10000, 12'hFFF, 1, 0, 32'h0A000FFF, 32'h0A000001);

        repeat (4) @(posedge clk);
        check("R1", "scoreboard drained", sb.size(), 32'd0);
        finish_run();
    end
endmodule